// File: doc/BRIEF.md
# Interrupt Request Conditioner

This block takes 23 asynchronous, active-low interrupt request lines and turns them into clean active-low interrupt outputs for a processor core. Each channel runs in one of two modes. In pulse mode a falling request produces one fixed-width low pulse. In hold mode the output stays low for as long as the request stays low, so the core sees one falling edge per request. Every request is resampled through a four-stage shift chain. The chain advances on a handler tick, an enable that fires on every second core clock. The whole block runs on the core clock.

Software picks the mode of each channel through two mode words on a 16-bit word-addressed peripheral bus. Two more bus addresses hold no data: a write to one of them sends a single-cycle release strobe to each hold-mode channel whose data bit is 1. That strobe empties the channel's sample chain and deasserts its output. The channel then waits until the request has been released before it can fire again.

Each channel is a four-state machine:
- IDLE: output high, waiting for a request.
- PULSE: one tick of low output.
- HOLD: low output for as long as the request stays low.
- BLOCKED: after a release strobe, waiting for the request to go high.

The transitions are:
- IDLE to PULSE: a falling sample in pulse mode.
- IDLE to HOLD: a falling sample in hold mode.
- PULSE to IDLE: at the next tick.
- HOLD to IDLE: when a high sample reaches the third chain stage.
- Any state to BLOCKED: a release strobe while the channel is in hold mode.
- BLOCKED to IDLE: at a tick where the chain is empty and the request is high.

Top module: `irqc_top`

## Requirements
- R1: After reset every `irq_n` bit is 1, and both mode words read back as 0, which puts every channel in pulse mode.
- R2: Bus addresses are BASE_ADDR (default 0x3800) plus an offset. Offset 0 holds the mode bits of channels 0..15, with bit n for channel n. Offset 1 holds the mode bits of channels 16..22 in bits 6:0, and its bits 15:7 read as 0. Offsets 2 and 3 are release addresses for channels 0..15 and 16..22 in the same bit layout, and both read as 0. A mode bit of 1 selects hold mode. A write to any other address changes nothing, and `bus_rdata` is 0 whenever `bus_en` is low.
- R3: The handler tick is active on every second core clock edge, starting with the second edge after reset is released. The output changes only at tick edges or at a release edge. A falling request drives the output low at the fourth tick edge that samples it low, so it appears 7 or 8 core cycles after the request falls, depending on the tick phase.
- R4: In pulse mode each falling request gives exactly one low pulse of 2 core cycles, however long the request stays low.
- R5: In hold mode the output stays low while the request stays low. It returns high 7 or 8 core cycles after the request is released.
- R6: A write to a release address, with bit n set, for a channel n in hold mode drives that output high at the clock edge that takes the write.
- R7: After a release, a channel whose request stays low stays high. It asserts again only once the request has gone high and then low again.
- R8: A release write has no effect on a channel whose data bit is 0, or on a channel in pulse mode.
- R9: A request held low for 2 core cycles is always recognised, and any low output lasts at least 2 core cycles unless a release strobe cuts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_n | input | NUM_CH | Active-low asynchronous interrupt requests |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 16 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| irq_n | output | NUM_CH | Active-low conditioned interrupt outputs |

## Verification
Register reads return their value in the same cycle, so they are checked 1 ns after the bus is driven. Release strobes act at the edge that takes the write, so their effect is checked at the very next falling clock edge. Assertion of an output takes four tick edges after the first low sample, and the checks accept exactly 7 or 8 cycles to cover both tick phases. Every other result is compared on every falling clock edge against a behavioural model that tracks the tick phase from reset, so a result that comes one cycle early or late is caught.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_PULSE   = 2'd1,
        CH_HOLD    = 2'd2,
        CH_BLOCKED = 2'd3
    } ch_state_e;

    localparam int unsigned BUS_W = 16;

endpackage

// File: rtl/irqc_tick.sv
module irqc_tick (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    logic phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
        end
    end

    assign tick = phase_q;

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs #(
    parameter int unsigned NUM_CH = 23,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h3800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] mode_bits,
    output logic [NUM_CH-1:0] clr_stb
);

    localparam int unsigned HI_W = NUM_CH - DATA_W;
    localparam logic [ADDR_W-1:0] A_MODE_LO = BASE_ADDR;
    localparam logic [ADDR_W-1:0] A_MODE_HI = BASE_ADDR + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_REL_LO  = BASE_ADDR + ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_REL_HI  = BASE_ADDR + ADDR_W'(3);

    logic [NUM_CH-1:0] mode_q;
    logic              wr;
    logic              rd;

    assign wr = bus_en & bus_we;
    assign rd = bus_en & ~bus_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr) begin
            if (bus_addr == A_MODE_LO) begin
                mode_q[DATA_W-1:0] <= bus_wdata;
            end
            if (bus_addr == A_MODE_HI) begin
                mode_q[NUM_CH-1:DATA_W] <= bus_wdata[HI_W-1:0];
            end
        end
    end

    always_comb begin
        clr_stb = '0;
        if (wr && bus_addr == A_REL_LO) begin
            clr_stb[DATA_W-1:0] = bus_wdata;
        end
        if (wr && bus_addr == A_REL_HI) begin
            clr_stb[NUM_CH-1:DATA_W] = bus_wdata[HI_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            if (bus_addr == A_MODE_LO) begin
                bus_rdata = mode_q[DATA_W-1:0];
            end else if (bus_addr == A_MODE_HI) begin
                bus_rdata[HI_W-1:0] = mode_q[NUM_CH-1:DATA_W];
            end
        end
    end

    assign mode_bits = mode_q;

endmodule

// File: rtl/irqc_chan.sv
module irqc_chan
    import irqc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic req_n,
    input  logic level_mode,
    input  logic clr,
    output logic irq_n
);

    localparam int unsigned NEW_IDX = SYNC_STAGES - 2;
    localparam int unsigned OLD_IDX = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain_q;
    ch_state_e              state_q;
    ch_state_e              state_d;
    logic                   seen;
    logic                   fall_evt;
    logic                   kill;

    assign seen     = chain_q[NEW_IDX];
    assign fall_evt = chain_q[NEW_IDX] & ~chain_q[OLD_IDX];
    assign kill     = clr & level_mode;

    // Sample chain on the inverted request; bit 0 is the newest sample.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (kill) begin
            chain_q <= '0;
        end else if (tick) begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], ~req_n};
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (kill) begin
            state_d = CH_BLOCKED;
        end else if (tick) begin
            unique case (state_q)
                CH_IDLE: begin
                    if (fall_evt) begin
                        state_d = level_mode ? CH_HOLD : CH_PULSE;
                    end
                end
                CH_PULSE: begin
                    state_d = CH_IDLE;
                end
                CH_HOLD: begin
                    if (!seen) begin
                        state_d = CH_IDLE;
                    end
                end
                CH_BLOCKED: begin
                    if (chain_q == '0 && req_n) begin
                        state_d = CH_IDLE;
                    end
                end
                default: state_d = CH_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            CH_PULSE, CH_HOLD: irq_n = 1'b0;
            default:           irq_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
    parameter int unsigned NUM_CH      = 23,
    parameter int unsigned SYNC_STAGES = 4,
    parameter logic [15:0] BASE_ADDR   = 16'h3800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] irq_req_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [15:0]       bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq_n
);

    logic              tick;
    logic [NUM_CH-1:0] mode_bits;
    logic [NUM_CH-1:0] clr_stb;

    irqc_tick u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    irqc_regs #(
        .NUM_CH    (NUM_CH),
        .DATA_W    (irqc_pkg::BUS_W),
        .ADDR_W    (16),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mode_bits (mode_bits),
        .clr_stb   (clr_stb)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        irqc_chan #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick),
            .req_n      (irq_req_n[g]),
            .level_mode (mode_bits[g]),
            .clr        (clr_stb[g]),
            .irq_n      (irq_n[g])
        );
    end

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int unsigned NUM_CH    = 23,
    parameter logic [15:0] BASE_ADDR = 16'h3800
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [NUM_CH-1:0] clr,
    input logic [NUM_CH-1:0] mode,
    input logic [NUM_CH-1:0] irq_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [15:0]       bus_addr,
    input logic [15:0]       bus_rdata
);

    localparam int unsigned HI_W = NUM_CH - 16;
    localparam logic [15:0] A_MODE_HI = BASE_ADDR + 16'd1;
    localparam logic [15:0] A_REL_LO  = BASE_ADDR + 16'd2;
    localparam logic [15:0] A_REL_HI  = BASE_ADDR + 16'd3;

    AST_REL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && (bus_addr == A_REL_LO || bus_addr == A_REL_HI)) |-> (bus_rdata == 16'h0000)); // R2
    AST_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr == A_MODE_HI) |-> (bus_rdata[15:HI_W] == '0)); // R2

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        AST_REL_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && mode[g]) |=> irq_n[g]); // R6
        AST_LOW_MIN_TWO: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(irq_n[g]) && !(clr[g] && mode[g])) |=> !irq_n[g]); // R9
        AST_MOVE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(irq_n[g]) |-> ($past(tick) || $past(clr[g] && mode[g]))); // R3
    end

endmodule

bind irqc_top irqc_checker #(
    .NUM_CH    (NUM_CH),
    .BASE_ADDR (BASE_ADDR)
) u_irqc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .clr       (clr_stb),
    .mode      (mode_bits),
    .irq_n     (irq_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata)
);

// File: tb/irqc_top_bench.sv
module irqc_top_bench;

    localparam int NUM_CH = 23;
    localparam logic [15:0] BASE = 16'h3800;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] irq_req_n = '1;
    logic              bus_en = 1'b0;
    logic              bus_we = 1'b0;
    logic [15:0]       bus_addr = '0;
    logic [15:0]       bus_wdata = '0;
    logic [15:0]       bus_rdata;
    logic [NUM_CH-1:0] irq_n;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irqc_top u_irqc_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req_n (irq_req_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_n     (irq_n)
    );

    // Behavioural reference: tick phase, sample history, per-channel state code
    // (0 idle, 1 pulse, 2 hold, 3 blocked).
    bit              m_tick;
    bit [NUM_CH-1:0] m_mode;
    int              m_hist [NUM_CH][4];
    int              m_st   [NUM_CH];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_tick = 0;
            m_mode = '0;
            for (int c = 0; c < NUM_CH; c++) begin
                m_st[c] = 0;
                for (int k = 0; k < 4; k++) m_hist[c][k] = 0;
            end
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                bit rel;
                bit empty;
                rel = bus_en && bus_we && m_mode[c] &&
                      ((c < 16 && bus_addr == BASE + 16'd2 && bus_wdata[c % 16]) ||
                       (c >= 16 && bus_addr == BASE + 16'd3 && bus_wdata[c - 16]));
                empty = (m_hist[c][0] + m_hist[c][1] + m_hist[c][2] + m_hist[c][3]) == 0;
                if (rel) begin
                    m_st[c] = 3;
                    for (int k = 0; k < 4; k++) m_hist[c][k] = 0;
                end else if (m_tick) begin
                    if (m_st[c] == 0 && m_hist[c][2] == 1 && m_hist[c][3] == 0)
                        m_st[c] = m_mode[c] ? 2 : 1;
                    else if (m_st[c] == 1)
                        m_st[c] = 0;
                    else if (m_st[c] == 2 && m_hist[c][2] == 0)
                        m_st[c] = 0;
                    else if (m_st[c] == 3 && empty && irq_req_n[c])
                        m_st[c] = 0;
                    for (int k = 3; k > 0; k--) m_hist[c][k] = m_hist[c][k-1];
                    m_hist[c][0] = irq_req_n[c] ? 0 : 1;
                end
            end
            if (bus_en && bus_we && bus_addr == BASE) m_mode[15:0] = bus_wdata;
            if (bus_en && bus_we && bus_addr == BASE + 16'd1) m_mode[NUM_CH-1:16] = bus_wdata[NUM_CH-17:0];
            m_tick = !m_tick;
        end
    end

    function automatic logic [NUM_CH-1:0] model_out();
        logic [NUM_CH-1:0] v;
        for (int c = 0; c < NUM_CH; c++) v[c] = !(m_st[c] == 1 || m_st[c] == 2);
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model covers R3, R4, R5, R7.
    always @(negedge clk) begin
        if (rst_n && cmp_on && !done)
            check(irq_n === model_out(), "R3 R4 R5 R7 model", 32'(irq_n), 32'(model_out()));
    end

    int fall_cnt [NUM_CH];
    logic [NUM_CH-1:0] prev_irq = '1;
    always @(negedge clk) begin
        for (int c = 0; c < NUM_CH; c++)
            if (prev_irq[c] && !irq_n[c]) fall_cnt[c]++;
        prev_irq = irq_n;
    end

    task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic bus_read(input logic [15:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a;
        #1;
        check(bus_rdata === exp, tag, 32'(bus_rdata), 32'(exp));
        @(negedge clk);
        bus_en = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        int cnt;
        int snap;
        for (int c = 0; c < NUM_CH; c++) fall_cnt[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_on = 1;
        @(negedge clk);
        check(irq_n === '1, "R1 outputs idle", 32'(irq_n), 32'h7FFFFF);
        bus_read(BASE, 16'h0000, "R1 mode low reset");
        bus_read(BASE + 16'd1, 16'h0000, "R1 mode high reset");

        // R2 register map
        bus_write(BASE + 16'd1, 16'hFFFF);
        bus_read(BASE + 16'd1, 16'h007F, "R2 mode high width");
        bus_write(BASE + 16'd1, 16'h0010);
        bus_write(BASE, 16'h0030);
        bus_read(BASE, 16'h0030, "R2 mode low readback");
        bus_read(BASE + 16'd1, 16'h0010, "R2 mode high readback");
        bus_write(BASE + 16'd4, 16'hFFFF);
        bus_read(BASE, 16'h0030, "R2 unmapped write ignored");
        bus_read(BASE + 16'd2, 16'h0000, "R2 release low reads zero");
        bus_read(BASE + 16'd3, 16'h0000, "R2 release high reads zero");

        // R3/R4: pulse channel 0
        @(negedge clk); irq_req_n[0] = 0; cnt = 0;
        while (irq_n[0] && cnt < 20) begin @(negedge clk); cnt++; end
        check(cnt == 7 || cnt == 8, "R3 assert latency", 32'(cnt), 32'd7);
        cnt = 0;
        while (!irq_n[0] && cnt < 10) begin @(negedge clk); cnt++; end
        check(cnt == 2, "R4 pulse width", 32'(cnt), 32'd2);
        snap = fall_cnt[0];
        repeat (40) @(negedge clk);
        check(fall_cnt[0] == snap, "R4 single pulse on long hold", 32'(fall_cnt[0]), 32'(snap));
        irq_req_n[0] = 1;
        repeat (12) @(negedge clk);

        // R5: hold channel 4
        snap = fall_cnt[4];
        irq_req_n[4] = 0;
        repeat (50) @(negedge clk);
        check(irq_n[4] === 1'b0, "R5 hold while low", 32'(irq_n[4]), 32'd0);
        check(fall_cnt[4] == snap + 1, "R5 one falling edge", 32'(fall_cnt[4]), 32'(snap + 1));
        irq_req_n[4] = 1;
        repeat (6) @(negedge clk);
        check(irq_n[4] === 1'b0, "R5 still low before release latency", 32'(irq_n[4]), 32'd0);
        repeat (3) @(negedge clk);
        check(irq_n[4] === 1'b1, "R5 released", 32'(irq_n[4]), 32'd1);

        // R6/R7/R8: release on channel 5 while channel 4 also holds
        irq_req_n[4] = 0; irq_req_n[5] = 0;
        repeat (20) @(negedge clk);
        check(irq_n[5:4] === 2'b00, "R5 both held", 32'(irq_n[5:4]), 32'd0);
        bus_write(BASE + 16'd2, 16'h0020);
        check(irq_n[5] === 1'b1, "R6 release drives high", 32'(irq_n[5]), 32'd1);
        check(irq_n[4] === 1'b0, "R8 zero bit unaffected", 32'(irq_n[4]), 32'd0);
        snap = fall_cnt[5];
        repeat (30) @(negedge clk);
        check(irq_n[5] === 1'b1 && fall_cnt[5] == snap, "R7 stays high while held", 32'(fall_cnt[5]), 32'(snap));
        irq_req_n[5] = 1; irq_req_n[4] = 1;
        repeat (20) @(negedge clk);
        irq_req_n[5] = 0;
        repeat (12) @(negedge clk);
        check(irq_n[5] === 1'b0, "R7 re-asserts after new fall", 32'(irq_n[5]), 32'd0);
        irq_req_n[5] = 1;
        repeat (12) @(negedge clk);

        // R8: release write to a pulse-mode channel does not disturb it
        @(negedge clk); irq_req_n[1] = 0;
        bus_write(BASE + 16'd2, 16'h0002);
        cnt = 2;
        while (irq_n[1] && cnt < 20) begin @(negedge clk); cnt++; end
        check(cnt == 7 || cnt == 8, "R8 pulse channel ignores release", 32'(cnt), 32'd7);
        irq_req_n[1] = 1;
        repeat (12) @(negedge clk);

        // R6 on the high release word, channel 20
        irq_req_n[20] = 0;
        repeat (14) @(negedge clk);
        check(irq_n[20] === 1'b0, "R5 channel 20 held", 32'(irq_n[20]), 32'd0);
        bus_write(BASE + 16'd3, 16'h0010);
        check(irq_n[20] === 1'b1, "R6 high release word", 32'(irq_n[20]), 32'd1);
        irq_req_n[20] = 1;
        repeat (12) @(negedge clk);

        // R9: minimum request width on pulse channel 17
        snap = fall_cnt[17];
        @(negedge clk); irq_req_n[17] = 0;
        repeat (2) @(negedge clk);
        irq_req_n[17] = 1;
        repeat (12) @(negedge clk);
        check(fall_cnt[17] == snap + 1, "R9 two-cycle request seen", 32'(fall_cnt[17]), 32'(snap + 1));

        // Mixed random traffic against the model
        bus_write(BASE, 16'hA5A5);
        bus_write(BASE + 16'd1, 16'h0055);
        repeat (3000) begin
            @(negedge clk);
            bus_en = 0; bus_we = 0;
            for (int c = 0; c < NUM_CH; c++)
                if ($urandom_range(0, 11) == 0) irq_req_n[c] = ~irq_req_n[c];
            if ($urandom_range(0, 39) == 0) begin
                bus_en = 1; bus_we = 1;
                bus_addr = ($urandom_range(0, 1) == 1) ? BASE + 16'd2 : BASE + 16'd3;
                bus_wdata = 16'($urandom);
            end
        end
        @(negedge clk);
        bus_en = 0; bus_we = 0;
        repeat (4) @(negedge clk);
        done = 1;
        summary();
    end

endmodule